// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus master and a memory port. It gives each bit of two real memory regions its own 32-bit word address. Two 32 MB alias windows start at 0x22000000 and 0x42000000. Any access that lands in one of them becomes an operation on a single bit of the real memory behind it. A read of an alias word returns the addressed bit as 0 or 1. A write sets or clears that bit with a locked read-modify-write at the access width, so the other bits of the real location are left as they were. Accesses outside both windows pass straight through to the memory port.

The upstream side has two valid/ready channels. The request channel carries address, write flag, size and write data. The response channel returns read data. The bridge holds at most one request at a time. It accepts a request (`req_ready` high) only when it is idle, and it keeps `req_ready` low until the response for that request has been taken. This back-pressure is what makes the read-modify-write atomic: no other upstream access can enter between the downstream read and the downstream write-back. Downstream, the memory request channel is also valid/ready. The memory response is a single-cycle strobe, and the bridge always accepts it because it has only one access outstanding.

Top module: `bitband_bridge`

## Requirements
- R1: An address whose bits [31:25] equal those of 0x22000000 or 0x42000000 is an alias access. Every other address is forwarded with its address, size, write flag and data unchanged, as exactly one downstream transaction.
- R2: For an alias access, the real byte address has the alias address bits [31:29] in bits [31:29] and alias bits [24:5] in bits [19:0]. All other bits are zero.
- R3: Size encoding is 0 = byte, 1 = halfword, 2 = word. The bit index is alias address bits [4:2] for a byte, [5:2] for a halfword and [6:2] for a word. For a halfword the real address has bit 0 cleared. For a word it has bits [1:0] cleared.
- R4: An alias read issues one downstream read at the real address and size. It returns the selected bit of the read data in bit 0 of the response, and every other response bit is zero.
- R5: An alias write issues a downstream read, then a downstream write to the same address with the same size. The written value equals the read value with only the selected bit changed, set when write data bit 0 is 1 and cleared when it is 0. Write data bits [31:1] have no effect.
- R6: `req_ready` is high only when no request is in progress. From the accepting edge until the response handshake, `req_ready` stays low, and no downstream request is made outside a request in progress.
- R7: `rsp_valid` stays high and `rsp_rdata` stays unchanged until `rsp_ready` is high.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the downstream request and its fields stay unchanged.
- R9: Size code 3 on an alias access is treated as a word: the downstream size is 2, the alignment is 4 bytes and the index is 5 bits. Memory data is little-endian and right-aligned: byte k of an access sits in data bits [8k+7:8k].
- R10: A pass-through read returns the downstream read data unchanged. Every write response, pass-through or alias, returns zero.
- R11: During and right after reset, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Bridge can take a request |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Response data |
| mem_req_valid | output | 1 | Downstream request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_addr | output | 32 | Downstream byte address |
| mem_write | output | 1 | Downstream write flag |
| mem_size | output | 2 | Downstream size code |
| mem_wdata | output | 32 | Downstream write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bound checker checks on every cycle that the upstream port stays stalled while a request is in progress, and that both outgoing channels hold steady under back-pressure. It also checks that alias responses carry nothing above bit 0, that alias downstream addresses are aligned to their size, and that each write-back goes to the same address and size as the read before it and differs from that read in at most one bit. Whether the right bit was chosen, whether the translated address is correct and whether the memory ends up holding the intended value can only be shown by the bench's scenarios. The bench holds its own memory image and reference copy and drives accesses at the window edges, in both windows, at every size, with stalls on both the memory and the response side.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } bb_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_A,
    ST_WAIT_A,
    ST_ISSUE_B,
    ST_WAIT_B,
    ST_RESP
  } bb_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              write;
    bb_size_e          size;
    logic [DATA_W-1:0] wdata;
  } bb_req_t;
endpackage

// File: rtl/bb_addr_xlate.sv
`timescale 1ns/1ps
module bb_addr_xlate
  import bb_pkg::*;
#(
  parameter int                       SPAN_LOG2 = 25,
  parameter int                       KEEP_HI   = 3,
  parameter int                       N_WIN     = 2,
  parameter logic [N_WIN*ADDR_W-1:0]  WIN_BASES = {32'h4200_0000, 32'h2200_0000}
) (
  input  logic [ADDR_W-1:0] addr,
  input  bb_size_e          size,
  output logic              is_alias,
  output logic [ADDR_W-1:0] real_addr,
  output logic [IDX_W-1:0]  bit_idx,
  output bb_size_e          eff_size
);
  localparam int STRIDE_LOG2 = $clog2(DATA_W / 8);
  localparam int SHIFT       = STRIDE_LOG2 + 3;
  localparam logic [ADDR_W-1:0] TAG_MASK  = {ADDR_W{1'b1}} << SPAN_LOG2;
  localparam logic [ADDR_W-1:0] SPAN_MASK = ~TAG_MASK;
  localparam logic [ADDR_W-1:0] HI_MASK   = ~({ADDR_W{1'b1}} >> KEEP_HI);

  logic [N_WIN-1:0] hit;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = WIN_BASES[w*ADDR_W +: ADDR_W];
    assign hit[w] = ((addr & TAG_MASK) == (BASE & TAG_MASK));
  end

  assign is_alias = |hit;
  assign eff_size = (size == SZ_WIDE) ? SZ_WORD : size;

  logic [ADDR_W-1:0] base_addr;
  logic [IDX_W-1:0]  raw_idx;

  always_comb begin
    base_addr = (addr & HI_MASK) | ((addr & SPAN_MASK) >> SHIFT);
    raw_idx   = addr[STRIDE_LOG2 +: IDX_W];
    real_addr = base_addr;
    bit_idx   = raw_idx;
    unique case (eff_size)
      SZ_BYTE: begin
        bit_idx = raw_idx & IDX_W'(7);
      end
      SZ_HALF: begin
        real_addr[0] = 1'b0;
        bit_idx      = raw_idx & IDX_W'(15);
      end
      default: begin
        real_addr[STRIDE_LOG2-1:0] = '0;
      end
    endcase
  end
endmodule

// File: rtl/bb_bit_merge.sv
`timescale 1ns/1ps
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  bb_size_e          size,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              set_val,
  output logic              bit_val,
  output logic [DATA_W-1:0] new_data
);
  logic [DATA_W-1:0] lane;
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] masked;

  always_comb begin
    unique case (size)
      SZ_BYTE: lane = DATA_W'(8'hFF);
      SZ_HALF: lane = DATA_W'(16'hFFFF);
      default: lane = '1;
    endcase
    sel      = DATA_W'(1) << bit_idx;
    masked   = rdata & lane;
    bit_val  = |(masked & sel);
    new_data = set_val ? (masked | sel) : (masked & ~sel);
  end
endmodule

// File: rtl/bb_seq.sv
`timescale 1ns/1ps
module bb_seq
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  bb_req_t           req,
  output logic [ADDR_W-1:0] cap_addr,
  output bb_size_e          cap_size,
  output logic              cap_set,
  input  logic              is_alias,
  input  logic [ADDR_W-1:0] real_addr,
  input  bb_size_e          eff_size,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] new_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output bb_size_e          mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rdata
);
  bb_state_e         state;
  bb_req_t           cap;
  logic [DATA_W-1:0] wb_q;
  logic [DATA_W-1:0] rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cap   <= '0;
      wb_q  <= '0;
      rsp_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cap   <= req;
            state <= ST_ISSUE_A;
          end
        end
        ST_ISSUE_A: begin
          if (mem_req_ready) state <= ST_WAIT_A;
        end
        ST_WAIT_A: begin
          if (mem_rsp_valid) begin
            if (is_alias && cap.write) begin
              wb_q  <= new_data;
              state <= ST_ISSUE_B;
            end else begin
              if (is_alias)       rsp_q <= DATA_W'(bit_val);
              else if (cap.write) rsp_q <= '0;
              else                rsp_q <= mem_rdata;
              state <= ST_RESP;
            end
          end
        end
        ST_ISSUE_B: begin
          if (mem_req_ready) state <= ST_WAIT_B;
        end
        ST_WAIT_B: begin
          if (mem_rsp_valid) begin
            rsp_q <= '0;
            state <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_rdata     = rsp_q;
  assign cap_addr      = cap.addr;
  assign cap_size      = cap.size;
  assign cap_set       = cap.wdata[0];
  assign mem_req_valid = (state == ST_ISSUE_A) || (state == ST_ISSUE_B);

  always_comb begin
    if (is_alias) begin
      mem_addr  = real_addr;
      mem_size  = eff_size;
      mem_write = (state == ST_ISSUE_B);
      mem_wdata = (state == ST_ISSUE_B) ? wb_q : '0;
    end else begin
      mem_addr  = cap.addr;
      mem_size  = cap.size;
      mem_write = cap.write;
      mem_wdata = cap.wdata;
    end
  end
endmodule

// File: rtl/bitband_bridge.sv
`timescale 1ns/1ps
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int                SPAN_LOG2  = 25,
  parameter logic [ADDR_W-1:0] WIN_BASE_A = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] WIN_BASE_B = 32'h4200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rdata
);
  bb_req_t           req_s;
  logic [ADDR_W-1:0] cap_addr;
  bb_size_e          cap_size;
  logic              cap_set;
  logic              is_alias;
  logic [ADDR_W-1:0] real_addr;
  logic [IDX_W-1:0]  bit_idx;
  bb_size_e          eff_size;
  logic              bit_val;
  logic [DATA_W-1:0] new_data;
  bb_size_e          mem_size_e;

  assign req_s.addr  = req_addr;
  assign req_s.write = req_write;
  assign req_s.size  = bb_size_e'(req_size);
  assign req_s.wdata = req_wdata;
  assign mem_size    = mem_size_e;

  bb_addr_xlate #(
    .SPAN_LOG2 (SPAN_LOG2),
    .KEEP_HI   (3),
    .N_WIN     (2),
    .WIN_BASES ({WIN_BASE_B, WIN_BASE_A})
  ) xlate_i (
    .addr      (cap_addr),
    .size      (cap_size),
    .is_alias  (is_alias),
    .real_addr (real_addr),
    .bit_idx   (bit_idx),
    .eff_size  (eff_size)
  );

  bb_bit_merge merge_i (
    .rdata    (mem_rdata),
    .size     (eff_size),
    .bit_idx  (bit_idx),
    .set_val  (cap_set),
    .bit_val  (bit_val),
    .new_data (new_data)
  );

  bb_seq seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req           (req_s),
    .cap_addr      (cap_addr),
    .cap_size      (cap_size),
    .cap_set       (cap_set),
    .is_alias      (is_alias),
    .real_addr     (real_addr),
    .eff_size      (eff_size),
    .bit_val       (bit_val),
    .new_data      (new_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_rdata     (rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_write     (mem_write),
    .mem_size      (mem_size_e),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rdata     (mem_rdata)
  );
endmodule

// File: rtl/bitband_bridge_chk.sv
`timescale 1ns/1ps
module bitband_bridge_chk
  import bb_pkg::*;
#(
  parameter int                SPAN_LOG2 = 25,
  parameter logic [ADDR_W-1:0] BASE_A    = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] BASE_B    = 32'h4200_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_write,
  input logic [1:0]        mem_size,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rdata
);
  localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << SPAN_LOG2;

  logic              busy;
  logic              ca_alias;
  logic              ca_write;
  logic              rd_pending;
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0]        rd_size;
  logic [DATA_W-1:0] rd_save;
  logic [DATA_W-1:0] lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ca_alias   <= 1'b0;
      ca_write   <= 1'b0;
      rd_pending <= 1'b0;
      rd_addr    <= '0;
      rd_size    <= '0;
      rd_save    <= '0;
    end else begin
      if (req_valid && req_ready) begin
        busy     <= 1'b1;
        ca_alias <= ((req_addr & TAG_MASK) == (BASE_A & TAG_MASK)) ||
                    ((req_addr & TAG_MASK) == (BASE_B & TAG_MASK));
        ca_write <= req_write;
      end else if (rsp_valid && rsp_ready) begin
        busy <= 1'b0;
      end
      if (mem_req_valid && mem_req_ready && !mem_write) begin
        rd_pending <= 1'b1;
        rd_addr    <= mem_addr;
        rd_size    <= mem_size;
      end else if (mem_rsp_valid && rd_pending) begin
        rd_pending <= 1'b0;
        rd_save    <= mem_rdata;
      end
    end
  end

  always_comb begin
    unique case (mem_size)
      2'd0:    lane = DATA_W'(8'hFF);
      2'd1:    lane = DATA_W'(16'hFFFF);
      default: lane = '1;
    endcase
  end

  a_r6_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r6_no_mem_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r8_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_write) &&
       $stable(mem_size) && $stable(mem_wdata)));

  a_r4_alias_read_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid && ca_alias && !ca_write) |-> (rsp_rdata[DATA_W-1:1] == '0));

  a_r10_write_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid && ca_write) |-> (rsp_rdata == '0));

  a_r3_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ca_alias && mem_req_valid && mem_size == 2'd1) |-> !mem_addr[0]);

  a_r3_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ca_alias && mem_req_valid && mem_size[1]) |-> (mem_addr[1:0] == 2'b00));

  a_r5_writeback_same_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ca_alias && mem_req_valid && mem_write) |->
      (mem_addr == rd_addr && mem_size == rd_size));

  a_r5_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ca_alias && mem_req_valid && mem_write) |->
      ($countones((mem_wdata ^ rd_save) & lane) <= 1));
endmodule

bind bitband_bridge bitband_bridge_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_write     (req_write),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .mem_write     (mem_write),
  .mem_size      (mem_size),
  .mem_wdata     (mem_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rdata     (mem_rdata)
);

// File: tb/bitband_bridge_tb_top.sv
`timescale 1ns/1ps
module bitband_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_write;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  bitband_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_write(mem_write), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0] mem  [logic [31:0]];
  logic [7:0] refm [logic [31:0]];

  function automatic logic [7:0] seed_byte(logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction
  function automatic logic [7:0] mget(logic [31:0] a);
    return mem.exists(a) ? mem[a] : seed_byte(a);
  endfunction
  function automatic logic [7:0] rget(logic [31:0] a);
    return refm.exists(a) ? refm[a] : seed_byte(a);
  endfunction
  function automatic int nbytes(logic [1:0] s);
    return (s >= 2'd2) ? 4 : (1 << s);
  endfunction
  function automatic logic [31:0] ref_real(logic [31:0] a, logic [1:0] s);
    logic [31:0] r;
    r = {a[31:29], 9'b0, a[24:5]};
    if (s == 2'd1) r[0] = 1'b0;
    if (s >= 2'd2) r[1:0] = 2'b00;
    return r;
  endfunction
  function automatic int ref_idx(logic [31:0] a, logic [1:0] s);
    if (s == 2'd0) return int'(a[4:2]);
    if (s == 2'd1) return int'(a[5:2]);
    return int'(a[6:2]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // downstream memory model
  int          cyc = 0;
  int          pend = 0;
  logic [31:0] pend_data = '0;
  int          ds_cnt = 0;
  int          ds_wr = 0;
  logic [31:0] ds_addr_rd = '0;
  logic [31:0] ds_addr_wr = '0;
  logic [1:0]  ds_size_rd = '0;
  logic [1:0]  ds_size_wr = '0;
  bit          ds_stall = 0;
  bit          prev_wait = 0;
  logic [31:0] prev_addr = '0;
  logic [31:0] prev_wdata = '0;

  always @(negedge clk) begin : responder
    logic [31:0] d;
    cyc++;
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      pend = 0;
      prev_wait = 0;
    end else begin
      if (prev_wait) begin
        check(mem_req_valid && mem_addr == prev_addr && mem_wdata == prev_wdata,
              "R8", "held mem request", mem_addr, prev_addr);
      end
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rdata = pend_data;
        end
      end
      mem_req_ready = ds_stall ? ((cyc % 3) == 0) : 1'b1;
      prev_wait = mem_req_valid && !mem_req_ready;
      prev_addr = mem_addr;
      prev_wdata = mem_wdata;
      if (mem_req_valid && mem_req_ready) begin
        d = '0;
        if (mem_write) begin
          for (int i = 0; i < nbytes(mem_size); i++) mem[mem_addr + i] = mem_wdata[8*i +: 8];
          ds_wr++;
          ds_addr_wr = mem_addr;
          ds_size_wr = mem_size;
        end else begin
          for (int i = 0; i < nbytes(mem_size); i++) d[8*i +: 8] = mget(mem_addr + i);
          ds_addr_rd = mem_addr;
          ds_size_rd = mem_size;
        end
        ds_cnt++;
        pend_data = d;
        pend = 1 + (ds_cnt % 3);
      end
    end
  end

  // per-cycle model of upstream occupancy
  bit tb_busy = 0;
  always @(negedge clk) begin
    if (rst_n && tb_busy) check(!req_ready, "R6", "ready while busy", {31'b0, req_ready}, 32'h0);
    if (rst_n && !tb_busy && mem_req_valid) check(1'b0, "R6", "mem req while idle", 32'h1, 32'h0);
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic txn(input logic [31:0] a, input bit w, input logic [1:0] s,
                     input logic [31:0] wd, input bit hold, output logic [31:0] rd);
    @(negedge clk);
    ds_cnt = 0;
    ds_wr = 0;
    req_addr = a; req_write = w; req_size = s; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    tb_busy = 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    if (hold) begin
      repeat (3) begin
        @(negedge clk);
        check(rsp_valid && rsp_rdata == rd, "R7", "held response", rsp_rdata, rd);
      end
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    tb_busy = 0;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic alias_read(input logic [31:0] a, input logic [1:0] s, input bit hold);
    logic [31:0] r, rd;
    int k;
    logic [7:0] b;
    r = ref_real(a, s);
    k = ref_idx(a, s);
    b = rget(r + 32'(k / 8));
    txn(a, 1'b0, s, 32'hFFFF_FFFF, hold, rd);
    check(rd == {31'b0, b[k % 8]}, "R4", "alias read bit", rd, {31'b0, b[k % 8]});
    check(ds_addr_rd == r, "R2", "real address", ds_addr_rd, r);
    check(ds_cnt == 1 && ds_wr == 0, "R4", "single read", 32'(ds_cnt), 32'd1);
    check(ds_size_rd == ((s == 2'd3) ? 2'd2 : s), "R9", "downstream size",
          {30'b0, ds_size_rd}, {30'b0, (s == 2'd3) ? 2'd2 : s});
  endtask

  task automatic alias_write(input logic [31:0] a, input logic [1:0] s,
                             input logic [31:0] wd, input bit hold);
    logic [31:0] r, rd, bw;
    int k;
    logic [7:0] b;
    r = ref_real(a, s);
    k = ref_idx(a, s);
    b = rget(r + 32'(k / 8));
    b[k % 8] = wd[0];
    refm[r + 32'(k / 8)] = b;
    txn(a, 1'b1, s, wd, hold, rd);
    check(rd == 32'h0, "R10", "alias write response", rd, 32'h0);
    check(ds_cnt == 2 && ds_wr == 1, "R5", "read then write", 32'(ds_cnt), 32'd2);
    check(ds_addr_wr == r && ds_addr_rd == r && ds_size_wr == ds_size_rd,
          "R5", "write-back location", ds_addr_wr, r);
    bw = {r[31:2], 2'b00};
    for (int i = 0; i < 4; i++)
      check(mget(bw + i) == rget(bw + i), "R5", "memory byte after write",
            {24'b0, mget(bw + i)}, {24'b0, rget(bw + i)});
  endtask

  task automatic pass_read(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] e, rd;
    e = '0;
    for (int i = 0; i < nbytes(s); i++) e[8*i +: 8] = rget(a + i);
    txn(a, 1'b0, s, 32'h0, 1'b0, rd);
    check(rd == e, "R10", "pass-through read data", rd, e);
    check(ds_cnt == 1 && ds_addr_rd == a && ds_size_rd == s, "R1", "forwarded read", ds_addr_rd, a);
  endtask

  task automatic pass_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] wd);
    logic [31:0] rd;
    for (int i = 0; i < nbytes(s); i++) refm[a + i] = wd[8*i +: 8];
    txn(a, 1'b1, s, wd, 1'b0, rd);
    check(rd == 32'h0, "R10", "pass-through write response", rd, 32'h0);
    check(ds_cnt == 1 && ds_wr == 1 && ds_addr_wr == a, "R1", "forwarded write", ds_addr_wr, a);
    for (int i = 0; i < 4; i++)
      check(mget(a + i) == rget(a + i), "R1", "pass-through memory",
            {24'b0, mget(a + i)}, {24'b0, rget(a + i)});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R11", "outputs in reset",
          {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R11", "outputs after reset",
          {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    // R2 R3 R4: reads at each size, both windows
    alias_read(32'h2200_0000, 2'd0, 0);
    alias_read(32'h2200_0014, 2'd0, 0);
    alias_read(32'h2212_345C, 2'd1, 0);
    alias_read(32'h2234_567C, 2'd2, 0);
    alias_read(32'h4200_0010, 2'd0, 0);
    alias_read(32'h43FF_FFFC, 2'd2, 0);
    alias_read(32'h4200_1038, 2'd1, 0);
    // R9: size 3 acts as word
    alias_read(32'h2200_0E6C, 2'd3, 0);

    // R5: set and clear at each size; upper write data bits ignored
    alias_write(32'h2200_0014, 2'd0, 32'h0000_0001, 0);
    alias_write(32'h2200_0014, 2'd0, 32'hFFFF_FFFE, 0);
    alias_write(32'h2200_0018, 2'd0, 32'hFFFF_FFFF, 0);
    alias_write(32'h4200_103C, 2'd1, 32'h0000_0001, 0);
    alias_write(32'h4200_1038, 2'd1, 32'h0000_0000, 0);
    alias_write(32'h2234_567C, 2'd2, 32'h8000_0000, 0);
    alias_write(32'h43FF_FFFC, 2'd2, 32'h0000_0001, 0);
    alias_read(32'h43FF_FFFC, 2'd2, 0);
    alias_read(32'h2200_0018, 2'd0, 0);

    // R1 R10: pass-through and window edges
    pass_read(32'h2000_0100, 2'd2);
    pass_write(32'h2000_0200, 2'd0, 32'hDEAD_BE3C);
    pass_read(32'h2000_0200, 2'd0);
    pass_read(32'h21FF_FFFC, 2'd2);
    pass_read(32'h2400_0000, 2'd2);
    pass_write(32'h4400_0010, 2'd1, 32'h0000_A55A);
    pass_read(32'h41FF_FFFE, 2'd1);
    alias_read(32'h23FF_FFFC, 2'd0, 0);

    // R7 R8: back-pressure on both sides
    ds_stall = 1;
    alias_read(32'h2200_0044, 2'd0, 1);
    alias_write(32'h2200_0044, 2'd0, 32'h1, 1);
    alias_write(32'h4200_2070, 2'd2, 32'h0, 1);
    pass_write(32'h2000_0300, 2'd2, 32'h1234_5678);
    pass_read(32'h2000_0300, 2'd2);
    ds_stall = 0;
    alias_read(32'h2200_0044, 2'd0, 0);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule